// File: doc/BRIEF.md
# Serial-in shift register with recirculating storage

The block converts a serial bit stream into a parallel word. A shift register takes one bit from the serial input on each falling edge of a shift strobe. The bit enters at bit 0 and moves toward the top bit. The top bit is always present on a serial output, so several blocks can be chained to build longer words. A rising edge of a separate store strobe copies the shift register into a storage register, and the storage register drives the parallel outputs.

A read/write control reverses the transfer. When it is high and the store strobe is also high, a falling shift edge loads the storage contents back into the shift register. An active-low select input freezes both registers when it is high.

The design runs on one system clock. All five asynchronous inputs (serial data, select, read/write and the two strobes) pass through a common synchronizer. Edges are detected only on the synchronized strobes, never on the control lines. As a result, a change on select or read/write cannot produce a false shift or store.

Top module: `sipo_recirc_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the shift and storage registers are cleared. After that edge `par_out` is 0 and `ser_out` is 0.
- R2: With `sel_n` low and `rw` low, a falling edge of `shift_stb` shifts the register up by one. `ser_in` enters bit 0, and `ser_out` shows bit WIDTH-1.
- R3: A rising edge of `shift_stb`, or a steady `shift_stb`, leaves the shift register unchanged.
- R4: With `sel_n` high, a falling edge of `shift_stb` neither shifts nor loads the shift register.
- R5: With `sel_n` low, `rw` high and `store_stb` high, a falling edge of `shift_stb` copies the storage register into the shift register and does not shift.
- R6: With `sel_n` low, `rw` high and `store_stb` low, a falling edge of `shift_stb` shifts, as in R2.
- R7: With `sel_n` low and `rw` low, a rising edge of `store_stb` copies the shift register into the storage register. That value appears on `par_out`.
- R8: When `sel_n` or `rw` is high, a rising edge of `store_stb` leaves the storage register unchanged.
- R9: Changes on `sel_n` or `rw` alone, with the strobes held steady, never shift, load or store.
- R10: An input change that is first sampled at clock edge m takes effect on the registers at clock edge m+2. This is a latency of two synchronizer stages.
- R11: A strobe level held for many cycles acts only once per edge. A held-high `store_stb` does not keep reloading the storage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data input |
| sel_n | input | 1 | Active-low select; high freezes both registers |
| rw | input | 1 | Read/write control; high selects recirculation and blocks storing |
| shift_stb | input | 1 | Shift strobe, acts on its falling edge |
| store_stb | input | 1 | Store strobe, acts on its rising edge |
| par_out | output | WIDTH | Storage register contents |
| ser_out | output | 1 | Top bit of the shift register, for cascading |

## Verification
The assertions assume that a strobe edge is judged against the control and data values that pass through the synchronizer in the same stage as that edge. For this reason, the properties look two and three cycles back at the ports, which matches the default of two stages. They also assume that no edge is judged on input values from before reset. A counter in the checker suppresses every property until three cycles after reset.

The stimulus changes inputs only at the falling clock edge. It holds every strobe level for several clock cycles, so each edge passes cleanly through the synchronizer. It changes the control lines only while the strobes are steady, except in the explicit R9 sequences.

// File: rtl/sipo_recirc_reg.sv
module sipo_recirc_reg #(
  parameter int WIDTH = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             sel_n,
  input  logic             rw,
  input  logic             shift_stb,
  input  logic             store_stb,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out
);
  // bundle order: {data, select_n, rw, shift strobe, store strobe}
  localparam logic [4:0] IDLE = 5'b01000;

  logic [SYNC-1:0][4:0] pipe;
  logic [4:0]           cur, prv;
  logic [WIDTH-1:0]     shreg, streg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {SYNC{IDLE}};
      prv  <= IDLE;
    end else begin
      pipe <= {pipe[SYNC-2:0], {ser_in, sel_n, rw, shift_stb, store_stb}};
      prv  <= pipe[SYNC-1];
    end
  end

  assign cur = pipe[SYNC-1];

  wire s_data = cur[4];
  wire s_seln = cur[3];
  wire s_rw   = cur[2];
  wire s_st   = cur[0];
  wire sh_fall = prv[1] & ~cur[1];
  wire st_rise = ~prv[0] & cur[0];

  wire do_shift = sh_fall & ~s_seln & ~(s_rw & s_st);
  wire do_load  = sh_fall & ~s_seln &  (s_rw & s_st);
  wire do_store = st_rise & ~s_seln & ~s_rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      streg <= '0;
    end else begin
      if (do_load)       shreg <= streg;
      else if (do_shift) shreg <= {shreg[WIDTH-2:0], s_data};
      if (do_store)      streg <= shreg;
    end
  end

  assign par_out = streg;
  assign ser_out = shreg[WIDTH-1];
endmodule

// File: rtl/sipo_recirc_reg_chk.sv
module sipo_recirc_reg_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_in,
  input logic             sel_n,
  input logic             rw,
  input logic             shift_stb,
  input logic             store_stb,
  input logic [WIDTH-1:0] par_out,
  input logic             ser_out,
  input logic [WIDTH-1:0] shreg,
  input logic [WIDTH-1:0] streg
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  wire ready = (since_rst == 2'd3);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (par_out == '0 && ser_out == 1'b0)); // R1

  AST_STORE_COPY: assert property (@(posedge clk) disable iff (rst)
    (ready && !$past(sel_n,2) && !$past(rw,2) && $past(store_stb,2) && !$past(store_stb,3))
    |=> par_out == $past(shreg)); // R7

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ready && !(!$past(sel_n,2) && !$past(rw,2) && $past(store_stb,2) && !$past(store_stb,3)))
    |=> $stable(par_out)); // R8

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ready && !(!$past(sel_n,2) && $past(shift_stb,3) && !$past(shift_stb,2)))
    |=> $stable(shreg)); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    (ready && !$past(sel_n,2) && $past(shift_stb,3) && !$past(shift_stb,2)
     && !($past(rw,2) && $past(store_stb,2)))
    |=> shreg == {$past(shreg[WIDTH-2:0]), $past(ser_in,3)}); // R2

  AST_RECIRC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ready && !$past(sel_n,2) && $past(shift_stb,3) && !$past(shift_stb,2)
     && $past(rw,2) && $past(store_stb,2))
    |=> shreg == $past(streg)); // R5
endmodule

bind sipo_recirc_reg sipo_recirc_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .ser_in(ser_in), .sel_n(sel_n), .rw(rw),
  .shift_stb(shift_stb), .store_stb(store_stb), .par_out(par_out),
  .ser_out(ser_out), .shreg(shreg), .streg(streg)
);

// File: tb/sipo_recirc_reg_bench.sv
module sipo_recirc_reg_bench;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_in = 1'b0, sel_n = 1'b1, rw = 1'b0, shift_stb = 1'b0, store_stb = 1'b0;
  logic [W-1:0] par_out;
  logic ser_out;
  int checks = 0, fails = 0;
  bit done = 0, armed = 0;

  sipo_recirc_reg #(.WIDTH(W)) u_sipo_recirc_reg (
    .clk(clk), .rst(rst), .ser_in(ser_in), .sel_n(sel_n), .rw(rw),
    .shift_stb(shift_stb), .store_stb(store_stb), .par_out(par_out), .ser_out(ser_out)
  );

  always #2.5 clk = ~clk;

  // reference model: input history with two-sample lag, behavioural registers
  typedef struct packed { logic si, cs, rw, sh, st; } smp_t;
  localparam smp_t RST_SMP = '{si:1'b0, cs:1'b1, rw:1'b0, sh:1'b0, st:1'b0};
  smp_t hist[$];
  smp_t c_s, p_s;
  logic [W-1:0] m_sh = '0, m_st = '0, old_sh;
  string tag = "R1";

  initial begin
    hist.push_front(RST_SMP); hist.push_front(RST_SMP); hist.push_front(RST_SMP);
  end

  always @(posedge clk) begin
    if (rst) begin
      m_sh = '0; m_st = '0; tag = "R1";
      hist.push_front(RST_SMP);
    end else begin
      c_s = hist[1]; p_s = hist[2]; old_sh = m_sh; tag = "R3";
      if (p_s.sh && !c_s.sh) begin
        if (c_s.cs) tag = "R4";
        else if (c_s.rw && c_s.st) begin m_sh = m_st; tag = "R5"; end
        else begin m_sh = {m_sh[W-2:0], c_s.si}; tag = c_s.rw ? "R6" : "R2"; end
      end
      if (!p_s.st && c_s.st) begin
        if (!c_s.cs && !c_s.rw) begin m_st = old_sh; tag = "R7"; end
        else tag = "R8";
      end
      hist.push_front('{si:ser_in, cs:sel_n, rw:rw, sh:shift_stb, st:store_stb});
    end
    while (hist.size() > 3) void'(hist.pop_back());
    armed = 1;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (armed && !done) begin
    chk(tag, par_out, m_st);
    chk(tag, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_sh[W-1]});
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; shift_stb = 1'b1; wait_n(4);
    shift_stb = 1'b0; wait_n(4);
  endtask

  task automatic store_pulse();
    store_stb = 1'b1; wait_n(4);
    store_stb = 1'b0; wait_n(4);
  endtask

  task automatic shift_word(input logic [W-1:0] v);
    for (int i = W-1; i >= 0; i--) shift_bit(v[i]);
  endtask

  initial begin
    logic [W-1:0] snap;
    wait_n(3);
    chk("R1", par_out, '0);
    chk("R1", {15'd0, ser_out}, 16'd0);
    rst = 1'b0; sel_n = 1'b0; wait_n(4);

    // R2 + R7: shift a word then store it
    shift_word(16'hA5C3);
    store_pulse();
    chk("R7", par_out, 16'hA5C3);

    // R10: latency of a store edge
    shift_bit(1'b1);                 // shift register now 4B87
    @(negedge clk) store_stb = 1'b1; // sampled at next edge m
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10", par_out, 16'hA5C3);
    @(posedge clk); @(negedge clk);
    chk("R10", par_out, 16'h4B87);

    // R11: held store high, keep shifting, storage must not reload
    shift_bit(1'b0); shift_bit(1'b0);
    wait_n(10);
    chk("R11", par_out, 16'h4B87);
    store_stb = 1'b0; wait_n(4);

    // R8: store blocked by rw high, then by select high
    rw = 1'b1; store_pulse(); chk("R8", par_out, 16'h4B87);
    rw = 1'b0; sel_n = 1'b1; wait_n(4); store_pulse(); chk("R8", par_out, 16'h4B87);

    // R4: shifting blocked by select high
    snap = par_out;
    shift_bit(1'b1); shift_bit(1'b1);
    sel_n = 1'b0; wait_n(4);
    store_pulse();
    chk("R4", par_out, 16'h2E1C);    // 4B87 shifted by two zeros, unchanged by R4 attempts

    // R5: recirculating load from storage
    store_stb = 1'b0; rw = 1'b1; wait_n(4);
    shift_stb = 1'b1; wait_n(4); store_stb = 1'b1; wait_n(4);
    shift_stb = 1'b0; wait_n(6);
    chk("R5", {15'd0, ser_out}, 16'd0);  // bit15 of 2E1C
    store_stb = 1'b0; wait_n(4);

    // R6: rw high with store low shifts; then store result
    shift_bit(1'b1);
    rw = 1'b0; wait_n(4); store_pulse();
    chk("R6", par_out, 16'h5C39);

    // R3 + R9: control toggles with strobes steady
    shift_stb = 1'b0; store_stb = 1'b0; wait_n(4);
    sel_n = 1'b1; wait_n(4); sel_n = 1'b0; wait_n(4);
    rw = 1'b1; wait_n(4); rw = 1'b0; wait_n(4);
    sel_n = 1'b1; rw = 1'b1; wait_n(4); sel_n = 1'b0; rw = 1'b0; wait_n(4);
    chk("R9", par_out, 16'h5C39);
    shift_stb = 1'b1; wait_n(6);
    store_pulse();
    chk("R3", par_out, 16'h5C39);
    shift_stb = 1'b0; wait_n(4);

    // mixed random traffic compared every cycle against the model
    for (int k = 0; k < 300; k++) begin
      ser_in = k[0] ^ k[3];
      sel_n  = (k % 7) == 3;
      rw     = (k % 5) == 2;
      shift_stb = k[1];
      store_stb = (k % 9) > 5;
      wait_n(4);
    end

    // reset in mid-stream
    rst = 1'b1; wait_n(2);
    chk("R1", par_out, '0);
    rst = 1'b0; wait_n(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule